// File: doc/BRIEF.md
# Level Alarm with Hysteresis

This block watches the stream of 12-bit conversion results from one channel and keeps two alarms on it: an upper alarm that trips when the signal climbs too high, and a lower alarm that trips when it sinks too low. Each alarm has a trip level and a separate release level. The alarm stays active until a sample crosses back past the release level. Samples that fall in the gap between the two levels leave the alarm as it is. This stops the alarm from chattering on a noisy signal.

Every alarm transition sets a sticky event flag. There is one "entered" flag and one "left" flag per alarm. Software clears a flag by writing 1 to its clear bit. The interrupt line is the OR of the flags that are enabled. For every sample, the block also returns a keep/drop decision one cycle later, which the sample store uses to drop samples selectively by region: upper alarm, lower alarm, or normal. The alarms are evaluated only while the channel runs in periodic sampling mode.

Top module: `lvl_alarm`

## Requirements
- R1: After reset, all four flags are 0, `irq` is 0, both alarms are inactive and `keep_valid` is 0.
- R2: While the upper alarm is inactive, a valid sample with value >= `hi_trig` makes `hi_active` 1 from the next cycle and sets flag bit 0 (upper entered).
- R3: While the upper alarm is active, a valid sample with value <= `hi_rel` makes `hi_active` 0 from the next cycle and sets flag bit 1 (upper left). Samples between `hi_rel` and `hi_trig` (exclusive) change neither the alarm nor the flags.
- R4: The lower alarm is the mirror case. A valid sample <= `lo_trig` activates it and sets flag bit 2 (lower entered). While it is active, a valid sample >= `lo_rel` releases it and sets flag bit 3 (lower left).
- R5: A 1 on a bit of `flag_clr` clears that flag at the next edge and leaves the other flags alone. A flag that is set by an event in the same cycle as its clear stays 1.
- R6: `irq` is 1 exactly when some flag bit is 1 and the matching bit of `irq_en` is 1. The enable bit order is the same as the flag bit order.
- R7: One cycle after each `sample_valid` pulse, `keep_valid` is 1 and `keep` gives the decision. The sample's region is the alarm state after that sample has been evaluated. The sample is dropped (`keep`=0) if it is in the upper region with `drop_hi`=1, or in the lower region with `drop_lo`=1, or in neither region with `drop_norm`=1.
- R8: While `periodic_mode` is 0, both alarms are forced inactive from the next cycle without setting any flag, and every sample is kept. While an alarm's own enable (`hi_en`, `lo_en`) is 0, that alarm is likewise held inactive with no event.
- R9: Each transition sets its flag only once. Further samples beyond the trip level while the alarm is already active do not set the "entered" flag again after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periodic_mode | input | 1 | Channel runs in periodic sampling mode |
| hi_en | input | 1 | Upper alarm enable |
| lo_en | input | 1 | Lower alarm enable |
| drop_hi | input | 1 | Drop samples in the upper-alarm region |
| drop_lo | input | 1 | Drop samples in the lower-alarm region |
| drop_norm | input | 1 | Drop samples in the normal region |
| hi_trig | input | 12 | Upper trip level |
| hi_rel | input | 12 | Upper release level |
| lo_trig | input | 12 | Lower trip level |
| lo_rel | input | 12 | Lower release level |
| sample_valid | input | 1 | One-cycle strobe for a new sample |
| sample_data | input | 12 | Sample value |
| flag_clr | input | 4 | Write-1-to-clear strobes for the flags |
| irq_en | input | 4 | Interrupt enable per flag |
| flags | output | 4 | Sticky events: 0 upper entered, 1 upper left, 2 lower entered, 3 lower left |
| irq | output | 1 | Interrupt request |
| hi_active | output | 1 | Upper alarm state |
| lo_active | output | 1 | Lower alarm state |
| keep_valid | output | 1 | Keep decision is valid |
| keep | output | 1 | 1 keeps the sample, 0 drops it |

## Verification
Samples are driven one below and one exactly at each trip level, so an off-by-one in the comparison shows up. Values inside the hysteresis band are then driven while the alarm is active, to separate true hysteresis from a single-threshold compare. Values exactly at each release level come next. A repeated over-limit sample after a clear tells edge-triggered flags from level-triggered ones. A clear that coincides with an event shows whether set or clear wins. Discard tests walk one sample through each region with each drop bit, to confirm that the region is taken from the updated alarm state.

// File: rtl/lvl_alarm_pkg.sv
package lvl_alarm_pkg;
  localparam int NUM_ALARM = 2;
  localparam int NUM_FLAG  = 2 * NUM_ALARM;
  // flag order: per alarm, entered then left; alarm 0 is upper
  localparam int F_HI_ON  = 0;
  localparam int F_HI_OFF = 1;
  localparam int F_LO_ON  = 2;
  localparam int F_LO_OFF = 3;

  typedef struct packed {
    logic hi;
    logic lo;
    logic norm;
  } drop_cfg_t;
endpackage

// File: rtl/lvl_alarm_det.sv
module lvl_alarm_det #(
  parameter int DW     = 12,
  parameter bit UPWARD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp,
  input  logic [DW-1:0] trig,
  input  logic [DW-1:0] rel,
  output logic          active,
  output logic          active_nxt,
  output logic          ev_on,
  output logic          ev_off
);
  logic hit_trig;
  logic hit_rel;

  generate
    if (UPWARD) begin : g_up
      assign hit_trig = (smp >= trig);
      assign hit_rel  = (smp <= rel);
    end else begin : g_dn
      assign hit_trig = (smp <= trig);
      assign hit_rel  = (smp >= rel);
    end
  endgenerate

  always_comb begin
    active_nxt = active;
    ev_on      = 1'b0;
    ev_off     = 1'b0;
    if (!enable) begin
      active_nxt = 1'b0;
    end else if (smp_vld) begin
      if (!active && hit_trig) begin
        active_nxt = 1'b1;
        ev_on      = 1'b1;
      end else if (active && hit_rel) begin
        active_nxt = 1'b0;
        ev_off     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else        active <= active_nxt;
  end
endmodule

// File: rtl/lvl_alarm_flags.sv
module lvl_alarm_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_nxt;
  logic         upd;

  always_comb begin
    flags_nxt = (flags & ~clr) | set;
    upd       = |{set, clr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= '0;
    else if (upd) flags <= flags_nxt;
  end

  assign irq = |(flags & en);
endmodule

// File: rtl/lvl_alarm.sv
module lvl_alarm
  import lvl_alarm_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          periodic_mode,
  input  logic          hi_en,
  input  logic          lo_en,
  input  logic          drop_hi,
  input  logic          drop_lo,
  input  logic          drop_norm,
  input  logic [DW-1:0] hi_trig,
  input  logic [DW-1:0] hi_rel,
  input  logic [DW-1:0] lo_trig,
  input  logic [DW-1:0] lo_rel,
  input  logic          sample_valid,
  input  logic [DW-1:0] sample_data,
  input  logic [3:0]    flag_clr,
  input  logic [3:0]    irq_en,
  output logic [3:0]    flags,
  output logic          irq,
  output logic          hi_active,
  output logic          lo_active,
  output logic          keep_valid,
  output logic          keep
);
  logic [NUM_ALARM-1:0]          al_en;
  logic [NUM_ALARM-1:0][DW-1:0]  al_trig;
  logic [NUM_ALARM-1:0][DW-1:0]  al_rel;
  logic [NUM_ALARM-1:0]          al_act;
  logic [NUM_ALARM-1:0]          al_nxt;
  logic [NUM_ALARM-1:0]          al_on;
  logic [NUM_ALARM-1:0]          al_off;
  logic [NUM_FLAG-1:0]           ev_set;
  drop_cfg_t                     drop_cfg;
  logic                          keep_nxt;

  assign al_en   = {lo_en & periodic_mode, hi_en & periodic_mode};
  assign al_trig = {lo_trig, hi_trig};
  assign al_rel  = {lo_rel, hi_rel};

  generate
    for (genvar g = 0; g < NUM_ALARM; g++) begin : g_alarm
      lvl_alarm_det #(
        .DW     (DW),
        .UPWARD (g == 0)
      ) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (al_en[g]),
        .smp_vld    (sample_valid),
        .smp        (sample_data),
        .trig       (al_trig[g]),
        .rel        (al_rel[g]),
        .active     (al_act[g]),
        .active_nxt (al_nxt[g]),
        .ev_on      (al_on[g]),
        .ev_off     (al_off[g])
      );
      assign ev_set[2*g]   = al_on[g];
      assign ev_set[2*g+1] = al_off[g];
    end
  endgenerate

  lvl_alarm_flags #(
    .N (NUM_FLAG)
  ) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev_set),
    .clr   (flag_clr),
    .en    (irq_en),
    .flags (flags),
    .irq   (irq)
  );

  assign hi_active = al_act[0];
  assign lo_active = al_act[1];

  // keep/drop decision, region taken from post-sample alarm state
  always_comb begin
    drop_cfg = '{hi: drop_hi, lo: drop_lo, norm: drop_norm};
    keep_nxt = 1'b1;
    if (periodic_mode) begin
      if ((al_nxt[0] && drop_cfg.hi) ||
          (al_nxt[1] && drop_cfg.lo) ||
          (!al_nxt[0] && !al_nxt[1] && drop_cfg.norm))
        keep_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) keep_valid <= 1'b0;
    else        keep_valid <= sample_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            keep <= 1'b1;
    else if (sample_valid) keep <= keep_nxt;
  end
endmodule

// File: rtl/lvl_alarm_chk.sv
module lvl_alarm_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          periodic_mode,
  input logic          hi_en,
  input logic [DW-1:0] hi_trig,
  input logic [DW-1:0] hi_rel,
  input logic          sample_valid,
  input logic [DW-1:0] sample_data,
  input logic [3:0]    flag_clr,
  input logic [3:0]    irq_en,
  input logic [3:0]    flags,
  input logic          irq,
  input logic          hi_active,
  input logic          lo_active,
  input logic          keep_valid
);
  a_r2_hi_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_active) |-> $past(sample_valid && periodic_mode && hi_en && (sample_data >= hi_trig)));

  a_r3_hi_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hi_active) && $past(periodic_mode && hi_en)) |-> $past(sample_valid && (sample_data <= hi_rel)));

  a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 4'b0000) |-> !irq);

  a_r7_keep_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> keep_valid);

  a_r7_keep_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> !keep_valid);

  a_r8_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    !periodic_mode |=> (!hi_active && !lo_active));
endmodule

bind lvl_alarm lvl_alarm_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .periodic_mode (periodic_mode),
  .hi_en         (hi_en),
  .hi_trig       (hi_trig),
  .hi_rel        (hi_rel),
  .sample_valid  (sample_valid),
  .sample_data   (sample_data),
  .flag_clr      (flag_clr),
  .irq_en        (irq_en),
  .flags         (flags),
  .irq           (irq),
  .hi_active     (hi_active),
  .lo_active     (lo_active),
  .keep_valid    (keep_valid)
);

// File: tb/sim_lvl_alarm.sv
`timescale 1ns/1ps
module sim_lvl_alarm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        periodic_mode = 1'b1;
  logic        hi_en = 1'b1, lo_en = 1'b1;
  logic        drop_hi = 1'b0, drop_lo = 1'b0, drop_norm = 1'b0;
  logic [11:0] hi_trig = 12'd3000, hi_rel = 12'd2970;
  logic [11:0] lo_trig = 12'd500,  lo_rel = 12'd530;
  logic        sample_valid = 1'b0;
  logic [11:0] sample_data = '0;
  logic [3:0]  flag_clr = '0, irq_en = '0;
  logic [3:0]  flags;
  logic        irq, hi_active, lo_active, keep_valid, keep;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  lvl_alarm u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int v);
    @(negedge clk); sample_valid = 1'b1; sample_data = v[11:0];
    @(negedge clk); sample_valid = 1'b0;
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 alarms", {hi_active, lo_active}, 0);
    chk("R1 keep_valid", keep_valid, 0);
  endtask

  task automatic t_high();
    send(2999); chk("R2 below trip", hi_active, 0); chk("R2 no flag", flags, 0);
    chk("R7 keep_valid", keep_valid, 1); chk("R7 keep normal", keep, 1);
    send(3000); chk("R2 at trip", hi_active, 1); chk("R2 flag0", flags, 4'b0001);
    send(2980); chk("R3 band holds", hi_active, 1); chk("R3 band no flag", flags, 4'b0001);
    clear(4'b0001); chk("R5 cleared", flags, 0);
    send(3500); chk("R9 no re-entry flag", flags, 0);
    send(2971); chk("R3 above rel", hi_active, 1);
    send(2970); chk("R3 at rel", hi_active, 0); chk("R3 flag1", flags, 4'b0010);
    clear(4'b1111);
  endtask

  task automatic t_low();
    send(501); chk("R4 above trip", lo_active, 0);
    send(500); chk("R4 at trip", lo_active, 1); chk("R4 flag2", flags, 4'b0100);
    send(520); chk("R4 band holds", lo_active, 1);
    send(530); chk("R4 at rel", lo_active, 0); chk("R4 flag3", flags, 4'b1100);
  endtask

  task automatic t_irq();
    @(negedge clk); irq_en = 4'b0000; #1 chk("R6 masked", irq, 0);
    irq_en = 4'b1000; #1 chk("R6 enabled", irq, 1);
    irq_en = 4'b0011; #1 chk("R6 other bits", irq, 0);
    clear(4'b0100); chk("R5 one bit only", flags, 4'b1000);
    irq_en = 4'b0000;
    clear(4'b1111);
  endtask

  task automatic t_race();
    @(negedge clk); sample_valid = 1'b1; sample_data = 12'd3100; flag_clr = 4'b0001;
    @(negedge clk); sample_valid = 1'b0; flag_clr = 4'b0000;
    chk("R5 set wins", flags, 4'b0001);
    send(2000); clear(4'b1111);
  endtask

  task automatic t_discard();
    drop_norm = 1'b1;
    send(1000); chk("R7 drop normal", keep, 0);
    send(3000); chk("R7 upper kept", keep, 1);
    drop_hi = 1'b1;
    send(3100); chk("R7 drop upper", keep, 0);
    send(2900); chk("R7 leaving upper is normal", keep, 0);
    drop_norm = 1'b0;
    send(2500); chk("R7 normal kept", keep, 1);
    drop_lo = 1'b1;
    send(400); chk("R7 drop lower", keep, 0);
    send(600); chk("R7 lower left kept", keep, 1);
    drop_hi = 1'b0; drop_lo = 1'b0;
    clear(4'b1111);
  endtask

  task automatic t_mode();
    send(3200); chk("R2 re-arm", hi_active, 1);
    clear(4'b1111);
    @(negedge clk); periodic_mode = 1'b0;
    @(negedge clk); chk("R8 forced off", hi_active, 0); chk("R8 no event", flags, 0);
    drop_norm = 1'b1;
    send(4000); chk("R8 no alarm", hi_active, 0); chk("R8 kept", keep, 1);
    @(negedge clk); periodic_mode = 1'b1; hi_en = 1'b0;
    send(4000); chk("R8 hi disabled", hi_active, 0); chk("R8 disabled no flag", flags, 0);
    hi_en = 1'b1; drop_norm = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_high();
    t_low();
    t_irq();
    t_race();
    t_discard();
    t_mode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule